// File: doc/BRIEF.md
# Per-Connection Cut-Through Cell Classifier

This block sits on a 32-bit cell path inside a chain of interface nodes, each with a processor attached. As each 53-byte cell arrives (fourteen words, the last padded), the block reads the connection number from the header word. It looks that number up in a local connection table and sends the cell to one of three places: the pass-through output toward the switch, the processor output, or both. The routing is settled once per cell, in a single decision cycle before the header word is accepted. The chosen route then holds for all fourteen words.

Each table entry carries three configuration bits, written by the host through a plain address/data/enable port. The block also keeps one activity bit per entry, which it maintains in hardware. An entry that belongs to the local processor begins idle. The first cell on an idle entry is diverted to the processor and makes the entry live. Once live, an entry with its forward bit set is cut through straight to the switch. A flow-reset cell returns the entry to idle. A backlog input from the outgoing side forces cut-through traffic back to the processor while it is high.

Top module: `vc_cut_classifier`

## Requirements
- R1: After reset, `in_ready`, `thru_valid` and `proc_valid` are all low, and every activity bit is cleared, so each owned entry starts idle.
- R2: The header word carries the connection number in bits 19:4 and the cell type in bits 3:1. A cell whose entry has its owned bit (`tw_data[0]`) clear goes only to the pass-through output, with every word unchanged. Entries never written since reset have the owned bit clear.
- R3: A connection number with any bit at or above `IDX_W` set has no entry. Such a cell goes only to the pass-through output, even when the entry at its low bits is owned.
- R4: A cell on an owned, idle entry goes only to the processor output and makes the entry live.
- R5: A cell on a live, owned entry with the forward bit (`tw_data[1]`) set and `backlog` low goes only to the pass-through output.
- R6: A cell on a live, owned entry with the forward bit clear goes only to the processor output.
- R7: A live, owned, forward entry with the copy bit (`tw_data[2]`) set sends each word to both outputs, with identical data on each.
- R8: A cell of type 3'b110 on an owned entry goes only to the processor and returns the entry to idle, so the next cell is diverted again.
- R9: When `backlog` is high during the decision cycle, a cell that would have been cut through goes only to the processor, and the entry stays live.
- R10: A host write that lands while a cell is in progress does not change that cell's route. The next cell follows the new entry.
- R11: A host write to an entry returns that entry to idle.
- R12: An output held off by its ready keeps its word stable. Words leave in arrival order, `*_last` marks word `CELL_WORDS-1`, and no word of a new cell is accepted in the cycle after a last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_data | input | WORD_W | Input cell word; word 0 is the header |
| backlog | input | 1 | Outgoing side is backed up; disables cut-through |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | IDX_W | Table entry index |
| tw_data | input | 3 | Entry bits: [0] owned, [1] forward, [2] copy |
| thru_valid | output | 1 | Pass-through word valid |
| thru_ready | input | 1 | Pass-through consumer ready |
| thru_data | output | WORD_W | Pass-through word |
| thru_last | output | 1 | Final word of the cell |
| proc_valid | output | 1 | Processor word valid |
| proc_ready | input | 1 | Processor consumer ready |
| proc_data | output | WORD_W | Processor word |
| proc_last | output | 1 | Final word of the cell |

## Verification
The hardest case to reach is a host write that lands on the same entry while a cell on it is partway through. A correct design and one that re-reads the table on every word only differ in that narrow window. The bench forks a cell transfer alongside a write issued a few cycles after the header. It then checks that all fourteen words went to the old destination and that the following cell went to the new one. A second hard case is a copied cell under independent back-pressure on both outputs. There, separate toggling patterns on the two ready inputs make each word complete its two deliveries in different cycles.

// File: rtl/vcc_pkg.sv
`timescale 1ns/1ps
package vcc_pkg;

   // Header word field positions (32-bit header word)
   localparam int HDR_VCI_LSB = 4;
   localparam int HDR_VCI_W   = 16;
   localparam int HDR_PT_LSB  = 1;
   localparam int HDR_PT_W    = 3;

   // Cell type that returns a connection to idle
   localparam logic [HDR_PT_W-1:0] PT_FLOW_RESET = 3'b110;

   typedef struct packed {
      logic copy;
      logic fwd;
      logic mine;
   } conn_cfg_t;

   typedef struct packed {
      logic to_thru;
      logic to_proc;
   } route_t;

endpackage

// File: rtl/vcc_conn_table.sv
`timescale 1ns/1ps
module vcc_conn_table
   import vcc_pkg::*;
#(
   parameter int IDX_W     = 10,
   parameter bit CFG_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output conn_cfg_t        rd_cfg,
   output logic             rd_active,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_val,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  conn_cfg_t        wr_cfg
);

   localparam int DEPTH = 1 << IDX_W;

   conn_cfg_t        cfg_q [DEPTH];
   logic [DEPTH-1:0] act_q;

   generate
      if (CFG_RESET) begin : g_cfg_flops
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cfg_q[i] <= '0;
            end else if (wr_en) begin
               cfg_q[wr_idx] <= wr_cfg;
            end
         end
      end else begin : g_cfg_array
         always_ff @(posedge clk) begin
            if (wr_en) cfg_q[wr_idx] <= wr_cfg;
         end
      end
   endgenerate

   // Activity bits: hardware updates, host write wins (clears to idle)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else begin
         if (upd_en) act_q[upd_idx] <= upd_val;
         if (wr_en)  act_q[wr_idx]  <= 1'b0;
      end
   end

   assign rd_cfg    = cfg_q[rd_idx];
   assign rd_active = act_q[rd_idx];

endmodule

// File: rtl/vcc_route_decide.sv
`timescale 1ns/1ps
module vcc_route_decide
   import vcc_pkg::*;
(
   input  logic      hit,
   input  logic      flow_reset,
   input  conn_cfg_t cfg,
   input  logic      active,
   input  logic      backlog,
   output route_t    route,
   output logic      upd_en,
   output logic      upd_val
);

   always_comb begin
      route   = '{to_thru: 1'b1, to_proc: 1'b0};
      upd_en  = 1'b0;
      upd_val = 1'b0;
      if (hit && cfg.mine) begin
         if (flow_reset) begin
            route   = '{to_thru: 1'b0, to_proc: 1'b1};
            upd_en  = 1'b1;
            upd_val = 1'b0;
         end else if (!active) begin
            route   = '{to_thru: 1'b0, to_proc: 1'b1};
            upd_en  = 1'b1;
            upd_val = 1'b1;
         end else if (cfg.fwd && !backlog) begin
            route   = '{to_thru: 1'b1, to_proc: cfg.copy};
         end else begin
            route   = '{to_thru: 1'b0, to_proc: 1'b1};
         end
      end
   end

endmodule

// File: rtl/vcc_cell_mover.sv
`timescale 1ns/1ps
module vcc_cell_mover
   import vcc_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int CELL_WORDS = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  route_t            route_d,
   output logic              decide,
   output logic              thru_valid,
   input  logic              thru_ready,
   output logic [WORD_W-1:0] thru_data,
   output logic              thru_last,
   output logic              proc_valid,
   input  logic              proc_ready,
   output logic [WORD_W-1:0] proc_data,
   output logic              proc_last
);

   localparam int CNT_W = $clog2(CELL_WORDS);

   typedef enum logic {S_IDLE, S_MOVE} mv_state_t;

   mv_state_t        st_q;
   route_t           rt_q;
   logic             t_done_q, p_done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             moving, t_need, p_need, accept, last_word;

   assign moving    = (st_q == S_MOVE);
   assign decide    = (st_q == S_IDLE) && in_valid;
   assign t_need    = rt_q.to_thru && !t_done_q;
   assign p_need    = rt_q.to_proc && !p_done_q;
   assign last_word = (cnt_q == CNT_W'(CELL_WORDS - 1));

   assign thru_valid = moving && in_valid && t_need;
   assign proc_valid = moving && in_valid && p_need;
   assign in_ready   = moving && (!t_need || thru_ready) && (!p_need || proc_ready);
   assign accept     = in_valid && in_ready;

   assign thru_data = in_data;
   assign proc_data = in_data;
   assign thru_last = last_word;
   assign proc_last = last_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         rt_q     <= '0;
         t_done_q <= 1'b0;
         p_done_q <= 1'b0;
         cnt_q    <= '0;
      end else if (decide) begin
         st_q     <= S_MOVE;
         rt_q     <= route_d;
         t_done_q <= 1'b0;
         p_done_q <= 1'b0;
         cnt_q    <= '0;
      end else if (moving) begin
         if (accept) begin
            t_done_q <= 1'b0;
            p_done_q <= 1'b0;
            if (last_word) begin
               st_q  <= S_IDLE;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end else begin
            if (thru_valid && thru_ready) t_done_q <= 1'b1;
            if (proc_valid && proc_ready) p_done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/vc_cut_classifier.sv
`timescale 1ns/1ps
module vc_cut_classifier
   import vcc_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int IDX_W      = 10,
   parameter int CELL_WORDS = 14,
   parameter bit CFG_RESET  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   input  logic              backlog,
   input  logic              tw_en,
   input  logic [IDX_W-1:0]  tw_addr,
   input  logic [2:0]        tw_data,
   output logic              thru_valid,
   input  logic              thru_ready,
   output logic [WORD_W-1:0] thru_data,
   output logic              thru_last,
   output logic              proc_valid,
   input  logic              proc_ready,
   output logic [WORD_W-1:0] proc_data,
   output logic              proc_last
);

   // Elaboration-time parameter checks
   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("vc_cut_classifier: WORD_W must be 32");
      end
      if (IDX_W < 1 || IDX_W > HDR_VCI_W) begin : g_bad_idx
         $error("vc_cut_classifier: IDX_W out of range");
      end
      if (CELL_WORDS < 2) begin : g_bad_cell
         $error("vc_cut_classifier: CELL_WORDS must be at least 2");
      end
   endgenerate

   logic [HDR_VCI_W-1:0] hdr_vci;
   logic [HDR_PT_W-1:0]  hdr_pt;
   logic [IDX_W-1:0]     hdr_idx;
   logic                 hdr_hit;
   logic                 decide;
   conn_cfg_t            ent_cfg;
   logic                 ent_active;
   route_t               route_d;
   logic                 dec_upd_en, dec_upd_val;

   assign hdr_vci = in_data[HDR_VCI_LSB +: HDR_VCI_W];
   assign hdr_pt  = in_data[HDR_PT_LSB  +: HDR_PT_W];
   assign hdr_idx = hdr_vci[IDX_W-1:0];

   generate
      if (IDX_W < HDR_VCI_W) begin : g_partial_table
         assign hdr_hit = (hdr_vci[HDR_VCI_W-1:IDX_W] == '0);
      end else begin : g_full_table
         assign hdr_hit = 1'b1;
      end
   endgenerate

   vcc_conn_table #(
      .IDX_W     (IDX_W),
      .CFG_RESET (CFG_RESET)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (hdr_idx),
      .rd_cfg    (ent_cfg),
      .rd_active (ent_active),
      .upd_en    (decide && dec_upd_en),
      .upd_idx   (hdr_idx),
      .upd_val   (dec_upd_val),
      .wr_en     (tw_en),
      .wr_idx    (tw_addr),
      .wr_cfg    (conn_cfg_t'(tw_data))
   );

   vcc_route_decide u_decide (
      .hit        (hdr_hit),
      .flow_reset (hdr_pt == PT_FLOW_RESET),
      .cfg        (ent_cfg),
      .active     (ent_active),
      .backlog    (backlog),
      .route      (route_d),
      .upd_en     (dec_upd_en),
      .upd_val    (dec_upd_val)
   );

   vcc_cell_mover #(
      .WORD_W     (WORD_W),
      .CELL_WORDS (CELL_WORDS)
   ) u_mover (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .route_d    (route_d),
      .decide     (decide),
      .thru_valid (thru_valid),
      .thru_ready (thru_ready),
      .thru_data  (thru_data),
      .thru_last  (thru_last),
      .proc_valid (proc_valid),
      .proc_ready (proc_ready),
      .proc_data  (proc_data),
      .proc_last  (proc_last)
   );

endmodule

// File: rtl/vcc_checker.sv
`timescale 1ns/1ps
module vcc_checker #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              thru_valid,
   input logic              thru_ready,
   input logic [WORD_W-1:0] thru_data,
   input logic              thru_last,
   input logic              proc_valid,
   input logic              proc_ready,
   input logic [WORD_W-1:0] proc_data
);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!in_ready && !thru_valid && !proc_valid))
      else $error("outputs active straight after reset");

   assert_copy_same_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (thru_valid && proc_valid) |-> (thru_data == proc_data))
      else $error("copied word differs between outputs");

   assert_hold_thru_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (thru_valid && !thru_ready) |=> (!in_valid || (thru_valid && $stable(thru_data))))
      else $error("pass-through word dropped while stalled");

   assert_hold_proc_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_valid && !proc_ready) |=> (!in_valid || (proc_valid && $stable(proc_data))))
      else $error("processor word dropped while stalled");

   assert_word_delivered_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (thru_valid || proc_valid))
      else $error("word accepted with no destination");

   assert_decision_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && thru_last) |=> !in_ready)
      else $error("new cell accepted without a decision cycle");

endmodule

bind vc_cut_classifier vcc_checker #(.WORD_W(WORD_W)) u_vcc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .thru_valid (thru_valid),
   .thru_ready (thru_ready),
   .thru_data  (thru_data),
   .thru_last  (thru_last),
   .proc_valid (proc_valid),
   .proc_ready (proc_ready),
   .proc_data  (proc_data)
);

// File: tb/vc_cut_classifier_bench.sv
`timescale 1ns/1ps
module vc_cut_classifier_bench;

   localparam int WW = 32;
   localparam int IW = 10;
   localparam int CW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [WW-1:0] in_data = '0;
   logic          backlog = 1'b0;
   logic          tw_en = 1'b0;
   logic [IW-1:0] tw_addr = '0;
   logic [2:0]    tw_data = '0;
   logic          thru_valid, thru_last, proc_valid, proc_last;
   logic          thru_ready = 1'b1;
   logic          proc_ready = 1'b1;
   logic [WW-1:0] thru_data, proc_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int t_cnt, p_cnt, t_bad, p_bad;
   logic [WW-1:0] t_hdr, p_hdr;

   always #10 clk = ~clk;

   vc_cut_classifier #(.WORD_W(WW), .IDX_W(IW), .CELL_WORDS(CW)) u_vc_cut_classifier (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .backlog(backlog),
      .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
      .thru_valid(thru_valid), .thru_ready(thru_ready), .thru_data(thru_data), .thru_last(thru_last),
      .proc_valid(proc_valid), .proc_ready(proc_ready), .proc_data(proc_data), .proc_last(proc_last)
   );

   // Output monitor: transfers are sampled mid-cycle, ahead of the completing edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (thru_valid && thru_ready) begin
            if (t_cnt == 0) t_hdr = thru_data;
            else if (thru_data[7:0] != 8'(t_cnt)) t_bad++;
            if (thru_last != (t_cnt == CW - 1)) t_bad++;
            t_cnt++;
         end
         if (proc_valid && proc_ready) begin
            if (p_cnt == 0) p_hdr = proc_data;
            else if (proc_data[7:0] != 8'(p_cnt)) p_bad++;
            if (proc_last != (p_cnt == CW - 1)) p_bad++;
            p_cnt++;
         end
      end
   end

   function automatic logic [WW-1:0] hdr(input logic [15:0] vci, input logic [2:0] pt);
      return {4'h0, 8'h2A, vci, pt, 1'b0};
   endfunction

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic clear_mon();
      t_cnt = 0; p_cnt = 0; t_bad = 0; p_bad = 0;
      t_hdr = '0; p_hdr = '0;
   endtask

   task automatic send_cell(input logic [15:0] vci, input logic [2:0] pt);
      for (int w = 0; w < CW; w++) begin
         in_data  = (w == 0) ? hdr(vci, pt) : {8'hC3, vci, 8'(w)};
         in_valid = 1'b1;
         do @(negedge clk); while (!in_ready);
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_data  = '0;
   endtask

   task automatic write_entry(input int idx, input logic [2:0] bits);
      @(posedge clk); #1;
      tw_en = 1'b1; tw_addr = IW'(idx); tw_data = bits;
      @(posedge clk); #1;
      tw_en = 1'b0;
   endtask

   task automatic verify_cell(input string req, input logic [15:0] vci, input logic [2:0] pt,
                              input int exp_t, input int exp_p);
      @(negedge clk);
      check({req, " pass-through words"}, t_cnt, exp_t * CW);
      check({req, " processor words"}, p_cnt, exp_p * CW);
      check({req, " order/last errors"}, t_bad + p_bad, 0);
      if (exp_t != 0) check({req, " pass-through header intact"}, int'(t_hdr == hdr(vci, pt)), 1);
      if (exp_p != 0) check({req, " processor header intact"}, int'(p_hdr == hdr(vci, pt)), 1);
   endtask

   task automatic cell_expect(input string req, input logic [15:0] vci, input logic [2:0] pt,
                              input int exp_t, input int exp_p);
      clear_mon();
      send_cell(vci, pt);
      verify_cell(req, vci, pt, exp_t, exp_p);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      @(negedge clk);
      check("R1 in_ready after reset", int'(in_ready), 0);
      check("R1 thru_valid after reset", int'(thru_valid), 0);
      check("R1 proc_valid after reset", int'(proc_valid), 0);
   endtask

   task automatic t_not_owned();
      cell_expect("R2 unwritten entry", 16'd100, 3'b000, 1, 0);
      write_entry(101, 3'b010);
      cell_expect("R2 forward but not owned", 16'd101, 3'b000, 1, 0);
   endtask

   task automatic t_out_of_range();
      write_entry(9, 3'b001);
      cell_expect("R3 high bits set", 16'h0409, 3'b000, 1, 0);
      cell_expect("R3 alias entry still idle (R4)", 16'd9, 3'b000, 0, 1);
   endtask

   task automatic t_first_then_cut();
      write_entry(5, 3'b011);
      cell_expect("R4 first cell diverted", 16'd5, 3'b000, 0, 1);
      cell_expect("R5 live forward entry cut through", 16'd5, 3'b000, 1, 0);
   endtask

   task automatic t_no_forward();
      write_entry(6, 3'b001);
      cell_expect("R4 first cell no-forward", 16'd6, 3'b000, 0, 1);
      cell_expect("R6 live no-forward entry", 16'd6, 3'b000, 0, 1);
   endtask

   task automatic t_copy();
      write_entry(7, 3'b111);
      cell_expect("R4 first cell copy entry", 16'd7, 3'b000, 0, 1);
      cell_expect("R7 copy to both", 16'd7, 3'b000, 1, 1);
   endtask

   task automatic t_flow_reset();
      cell_expect("R8 reset cell to processor", 16'd5, 3'b110, 0, 1);
      cell_expect("R8 entry idle after reset cell", 16'd5, 3'b000, 0, 1);
      cell_expect("R8 entry live again", 16'd5, 3'b000, 1, 0);
   endtask

   task automatic t_backlog();
      backlog = 1'b1;
      cell_expect("R9 backlog diverts forward entry", 16'd5, 3'b000, 0, 1);
      cell_expect("R9 backlog diverts copy entry", 16'd7, 3'b000, 0, 1);
      backlog = 1'b0;
      cell_expect("R9 entry stayed live", 16'd5, 3'b000, 1, 0);
   endtask

   task automatic t_mid_cell_write();
      write_entry(8, 3'b001);
      cell_expect("R4 first cell entry 8", 16'd8, 3'b000, 0, 1);
      clear_mon();
      fork
         send_cell(16'd8, 3'b000);
         begin
            repeat (4) @(posedge clk);
            #1;
            tw_en = 1'b1; tw_addr = IW'(8); tw_data = 3'b000;
            @(posedge clk); #1;
            tw_en = 1'b0;
         end
      join
      verify_cell("R10 cell in flight keeps route", 16'd8, 3'b000, 0, 1);
      cell_expect("R10 next cell uses new entry", 16'd8, 3'b000, 1, 0);
   endtask

   task automatic t_rewrite_idle();
      write_entry(5, 3'b011);
      cell_expect("R11 rewrite returns entry to idle", 16'd5, 3'b000, 0, 1);
      cell_expect("R11 entry live after rewrite", 16'd5, 3'b000, 1, 0);
   endtask

   task automatic t_stalls();
      clear_mon();
      fork
         send_cell(16'd5, 3'b000);
         begin
            for (int i = 0; i < 40; i++) begin
               @(posedge clk); #1;
               thru_ready = ~thru_ready;
            end
            thru_ready = 1'b1;
         end
      join
      verify_cell("R12 pass-through stall", 16'd5, 3'b000, 1, 0);

      clear_mon();
      fork
         send_cell(16'd6, 3'b000);
         begin
            for (int i = 0; i < 40; i++) begin
               @(posedge clk); #1;
               proc_ready = (i % 3 != 0);
            end
            proc_ready = 1'b1;
         end
      join
      verify_cell("R12 processor stall", 16'd6, 3'b000, 0, 1);

      clear_mon();
      fork
         send_cell(16'd7, 3'b000);
         begin
            for (int i = 0; i < 60; i++) begin
               @(posedge clk); #1;
               thru_ready = (i % 2 == 0);
               proc_ready = (i % 3 != 1);
            end
            thru_ready = 1'b1;
            proc_ready = 1'b1;
         end
      join
      verify_cell("R12 R7 copy under split stalls", 16'd7, 3'b000, 1, 1);
   endtask

   initial begin
      clear_mon();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset_state();
      t_not_owned();
      t_out_of_range();
      t_first_then_cut();
      t_no_forward();
      t_copy();
      t_flow_reset();
      t_backlog();
      t_mid_cell_write();
      t_rewrite_idle();
      t_stalls();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule